// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Model

This block is a synthesizable behavioural model of a synchronous static RAM whose write data trails its command by the same number of cycles as read data. A bus master can therefore issue read, write, read with no idle cycle between them, and the shared data bus never needs a turnaround slot. The array is small and parameterised. Each word is made of byte lanes, by default eight lanes of nine bits. Address, the three chip selects, the write strobe, the lane write enables, the advance/load select and the clock enable are all registered on the rising clock edge.

A static timing input chooses between two timings. In pipelined timing, read data passes through an output register. In flow-through timing, read data comes straight from the array and both pipelines are one stage shorter. A two-bit burst counter lets one loaded address be followed by three more accesses of the same kind. The burst order is either linear or interleaved. Output enable and sleep act on the output drivers without waiting for a clock edge. The bidirectional data bus is split into `din`, `dout` and a drive flag `dout_en`.

Top module: `latewrite_sram`

## Requirements
- R1: While reset is asserted and after it is released, `dout_en` is low until a read reaches the output stage.
- R2: A command is accepted only when `sel_a_n` is low, `sel_b` is high and `sel_c_n` is low. With any one of them inactive, a load cycle is a deselect: it neither drives the bus nor writes the array.
- R3: In pipelined timing (`flow_thru` = 0), a read loaded on edge N drives `dout` from edge N+1 onward.
- R4: In pipelined timing, the data of a write loaded on edge N is taken from `din` on edge N+2.
- R5: In flow-through timing (`flow_thru` = 1), a read loaded on edge N drives `dout` right after edge N, and the data of a write loaded on edge N is taken from `din` on edge N+1.
- R6: Lane i (bits i*9+8..i*9) is written only when `byte_wr_n[i]` is low. A write with all lane enables high changes nothing and still takes its pipeline slot.
- R7: With `advance` high, a cycle repeats the type of the previous command (read, write or deselect) and ignores `wr_n` and the selects. The low two address bits step as start+k modulo 4 when `interleave` is 0, and as start XOR k when `interleave` is 1.
- R8: With `clk_en_n` high, an edge changes nothing: pipeline, burst state and outputs hold, and inputs on that edge are ignored.
- R9: `out_en_n` high or `sleep` high turns `dout_en` off at once, without a clock edge. Cycles that carry write data never drive the bus.
- R10: A pipelined read of an address whose write data is being taken on the read's output edge returns the new lanes merged over the old word.
- R11: Reads and writes may alternate on consecutive edges with no idle cycle, and every access keeps its own data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of pipeline and burst state |
| clk_en_n | input | 1 | Active-low clock enable; high stalls the block |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Low selects write, high selects read, on a load cycle |
| byte_wr_n | input | LANES | Active-low lane write enables |
| advance | input | 1 | High continues the burst, low loads a new command |
| addr | input | ADDR_W | Word address |
| din | input | LANES*LANE_W | Write data |
| flow_thru | input | 1 | Static timing select: 1 flow-through, 0 pipelined |
| interleave | input | 1 | Burst order: 0 linear, 1 interleaved |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Blocks operation and turns outputs off |
| dout | output | LANES*LANE_W | Read data |
| dout_en | output | 1 | Data bus is driven |

## Verification
The assertions assume that `interleave` changes only on a load cycle, never in the middle of a burst, and that `flow_thru` changes only while both pipeline stages hold deselects. The linear-step property depends on the first of these. The stimulus switches burst order only on the cycle that loads a new address, and switches timing only after several deselect cycles. Before any burst continuation, a load cycle has set the start address, so the counter relation holds from reset onward.

// File: rtl/latewrite_sram.sv
`timescale 1ns/1ps
module latewrite_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 8,
  parameter int LANE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clk_en_n,
  input  logic                     sel_a_n,
  input  logic                     sel_b,
  input  logic                     sel_c_n,
  input  logic                     wr_n,
  input  logic [LANES-1:0]         byte_wr_n,
  input  logic                     advance,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [LANES*LANE_W-1:0]  din,
  input  logic                     flow_thru,
  input  logic                     interleave,
  input  logic                     out_en_n,
  input  logic                     sleep,
  output logic [LANES*LANE_W-1:0]  dout,
  output logic                     dout_en
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  typedef enum logic [1:0] {OP_IDLE = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2} op_e;

  logic [DATA_W-1:0] mem [DEPTH];
  op_e               a_op, b_op, cmd_op;
  logic [ADDR_W-1:0] a_addr, b_addr, base_q, cmd_addr, wr_addr;
  logic [LANES-1:0]  a_bw, b_bw, wr_bw;
  logic [1:0]        cnt_q, cnt_nx, low_nx;
  logic [DATA_W-1:0] rd_word, rd_q;
  logic              step, sel, wr_go;

  assign step   = !clk_en_n && !sleep;
  assign sel    = !sel_a_n && sel_b && !sel_c_n;
  assign cnt_nx = cnt_q + 2'd1;
  assign low_nx = interleave ? (base_q[1:0] ^ cnt_nx) : (base_q[1:0] + cnt_nx);

  always_comb begin
    if (!advance) begin
      cmd_op   = !sel ? OP_IDLE : (wr_n ? OP_RD : OP_WR);
      cmd_addr = addr;
    end else begin
      cmd_op   = a_op;
      cmd_addr = {base_q[ADDR_W-1:2], low_nx};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_op   <= OP_IDLE;
      b_op   <= OP_IDLE;
      a_addr <= '0;
      b_addr <= '0;
      a_bw   <= '1;
      b_bw   <= '1;
      base_q <= '0;
      cnt_q  <= '0;
      rd_q   <= '0;
    end else if (step) begin
      a_op   <= cmd_op;
      a_addr <= cmd_addr;
      a_bw   <= byte_wr_n;
      b_op   <= a_op;
      b_addr <= a_addr;
      b_bw   <= a_bw;
      rd_q   <= rd_word;
      if (!advance) begin
        base_q <= addr;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_nx;
      end
    end
  end

  assign wr_go   = step && (flow_thru ? (a_op == OP_WR) : (b_op == OP_WR));
  assign wr_addr = flow_thru ? a_addr : b_addr;
  assign wr_bw   = flow_thru ? a_bw : b_bw;

  always_comb begin
    rd_word = mem[a_addr];
    for (int i = 0; i < LANES; i++)
      if (wr_go && wr_addr == a_addr && !wr_bw[i])
        rd_word[i*LANE_W +: LANE_W] = din[i*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (wr_go)
      for (int i = 0; i < LANES; i++)
        if (!wr_bw[i]) mem[wr_addr][i*LANE_W +: LANE_W] <= din[i*LANE_W +: LANE_W];
  end

  assign dout    = flow_thru ? rd_word : rd_q;
  assign dout_en = !sleep && !out_en_n && (flow_thru ? (a_op == OP_RD) : (b_op == OP_RD));

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(a_op) && $stable(b_op) && $stable(a_addr) && $stable(rd_q));
  p_desel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !advance && !sel) |=> (a_op == OP_IDLE));
  p_cont_type_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && advance) |=> (a_op == $past(a_op)));
  p_linear_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && advance && !interleave) |=> (a_addr[1:0] == $past(a_addr[1:0]) + 2'd1));
  p_pipe_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow_thru && step && a_op == OP_RD) |=> (b_op == OP_RD));
  p_pipe_wr_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow_thru && b_op == OP_WR) |-> !dout_en);
  p_flow_wr_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_thru && a_op == OP_WR) |-> !dout_en);
endmodule

// File: tb/latewrite_sram_tb.sv
`timescale 1ns/1ps
module latewrite_sram_tb;
  logic        clk = 1'b0, rst_n = 1'b0, clk_en_n = 1'b0;
  logic        sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1, wr_n = 1'b1;
  logic [7:0]  byte_wr_n = 8'hFF;
  logic        advance = 1'b0;
  logic [5:0]  addr = '0;
  logic [71:0] din = '0;
  logic        flow_thru = 1'b0, interleave = 1'b0, out_en_n = 1'b0, sleep = 1'b0;
  logic [71:0] dout;
  logic        dout_en;
  int          checks = 0, errors = 0;

  latewrite_sram u_dut (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .wr_n(wr_n), .byte_wr_n(byte_wr_n), .advance(advance), .addr(addr),
    .din(din), .flow_thru(flow_thru), .interleave(interleave), .out_en_n(out_en_n),
    .sleep(sleep), .dout(dout), .dout_en(dout_en));

  always #10 clk = ~clk;

  localparam logic [71:0] DA = 72'h0123456789ABCDEF01;
  localparam logic [71:0] DB = 72'hFEDCBA9876543210AA;
  localparam logic [71:0] DC = 72'h0000000000000001A5;
  localparam logic [71:0] DM = {DA[71:9], DC[8:0]};
  localparam logic [71:0] DX = 72'h5A5A5A5A5A5A5A5A5A;
  localparam logic [71:0] DY = 72'h3C3C3C3C3C3C3C3C3C;
  localparam logic [71:0] ONES = '1;

  typedef struct packed {
    logic adv; logic wn; logic sl; logic [7:0] bw; logic [5:0] ad;
    logic [71:0] di; logic en; logic [71:0] ex;
  } vec_t;

  localparam vec_t TBL [14] = '{
    '{1'b0, 1'b0, 1'b1, 8'h00, 6'd4, 72'h0, 1'b0, 72'h0},
    '{1'b0, 1'b0, 1'b1, 8'h00, 6'd5, 72'h0, 1'b0, 72'h0},
    '{1'b0, 1'b1, 1'b1, 8'hFF, 6'd4, DA,    1'b0, 72'h0},
    '{1'b0, 1'b1, 1'b1, 8'hFF, 6'd5, DB,    1'b1, DA},
    '{1'b0, 1'b0, 1'b1, 8'hFE, 6'd4, 72'h0, 1'b1, DB},
    '{1'b0, 1'b1, 1'b1, 8'hFF, 6'd4, 72'h0, 1'b0, 72'h0},
    '{1'b0, 1'b1, 1'b1, 8'hFF, 6'd5, DC,    1'b1, DM},
    '{1'b0, 1'b1, 1'b0, 8'hFF, 6'd0, 72'h0, 1'b1, DB},
    '{1'b0, 1'b1, 1'b0, 8'hFF, 6'd0, 72'h0, 1'b0, 72'h0},
    '{1'b0, 1'b0, 1'b1, 8'hFF, 6'd5, 72'h0, 1'b0, 72'h0},
    '{1'b0, 1'b1, 1'b0, 8'hFF, 6'd0, 72'h0, 1'b0, 72'h0},
    '{1'b0, 1'b1, 1'b0, 8'hFF, 6'd0, ONES,  1'b0, 72'h0},
    '{1'b0, 1'b1, 1'b1, 8'hFF, 6'd5, 72'h0, 1'b0, 72'h0},
    '{1'b0, 1'b1, 1'b0, 8'hFF, 6'd0, 72'h0, 1'b1, DB}
  };

  function automatic logic [71:0] pat(int k);
    return {8{9'(k * 37 + 11)}};
  endfunction

  task automatic drive(logic a, logic w, logic s, logic [7:0] b, logic [5:0] ad, logic [71:0] d);
    advance = a; wr_n = w; sel_a_n = !s; sel_b = s; sel_c_n = !s;
    byte_wr_n = b; addr = ad; din = d;
  endtask

  task automatic tick;
    @(posedge clk); #5;
  endtask

  task automatic expect_out(string tag, logic en, logic [71:0] d);
    checks++;
    if (dout_en !== en || (en && dout !== d)) begin
      errors++;
      $display("FAIL %s: actual en=%0b data=%h expected en=%0b data=%h", tag, dout_en, dout, en, d);
    end
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    tick(); tick();
    expect_out("R1 in reset", 1'b0, 72'h0);
    rst_n = 1'b1;
    tick();
    expect_out("R1 after reset", 1'b0, 72'h0);

    for (int i = 0; i < 14; i++) begin
      drive(TBL[i].adv, TBL[i].wn, TBL[i].sl, TBL[i].bw, TBL[i].ad, TBL[i].di);
      tick();
      expect_out($sformatf("R3 R4 R6 R10 R11 table row %0d", i), TBL[i].en, TBL[i].ex);
    end

    // R2: one select inactive per cycle
    drive(1'b0, 1'b1, 1'b1, 8'hFF, 6'd5, 72'h0); sel_b = 1'b0;
    tick(); expect_out("R2 read cycle", 1'b0, 72'h0);
    drive(1'b0, 1'b0, 1'b1, 8'h00, 6'd5, 72'h0); sel_c_n = 1'b1;
    tick(); expect_out("R2 read with sel_b low", 1'b0, 72'h0);
    drive(1'b0, 1'b1, 1'b0, 8'hFF, 6'd0, 72'h0);
    tick(); expect_out("R2 write with sel_c_n high", 1'b0, 72'h0);
    drive(1'b0, 1'b1, 1'b0, 8'hFF, 6'd0, ONES);
    tick();
    drive(1'b0, 1'b1, 1'b1, 8'hFF, 6'd5, 72'h0);
    tick();
    drive(1'b0, 1'b1, 1'b0, 8'hFF, 6'd0, 72'h0);
    tick(); expect_out("R2 deselected write left data", 1'b1, DB);

    // R8 stall with a read held on the bus, R9 asynchronous controls
    clk_en_n = 1'b1;
    drive(1'b0, 1'b1, 1'b1, 8'hFF, 6'd4, 72'h0);
    for (int k = 0; k < 3; k++) begin
      tick(); expect_out("R8 stalled read holds", 1'b1, DB);
    end
    out_en_n = 1'b1; #1; expect_out("R9 output enable off", 1'b0, 72'h0);
    out_en_n = 1'b0; #1; expect_out("R9 output enable on", 1'b1, DB);
    sleep = 1'b1;    #1; expect_out("R9 sleep off", 1'b0, 72'h0);
    sleep = 1'b0;    #1;
    clk_en_n = 1'b0;
    drive(1'b0, 1'b1, 1'b0, 8'hFF, 6'd0, 72'h0);
    tick(); expect_out("R8 resume", 1'b0, 72'h0);
    tick(); expect_out("R8 stalled command ignored", 1'b0, 72'h0);

    // R7 linear write burst then interleaved read burst, back to back (R11)
    for (int i = 0; i < 9; i++) begin
      logic [71:0] d;
      d = (i >= 2 && i <= 5) ? pat(i - 2) : 72'h0;
      interleave = (i >= 4);
      if (i < 4)      drive(i != 0, i != 0, 1'b1, 8'h00, i == 0 ? 6'd8 : 6'd0, d);
      else if (i < 8) drive(i != 4, i == 4, 1'b1, 8'hFF, i == 4 ? 6'd9 : 6'd0, d);
      else            drive(1'b0, 1'b1, 1'b0, 8'hFF, 6'd0, d);
      tick();
      if (i >= 5) begin
        int order [4] = '{1, 0, 3, 2};
        expect_out($sformatf("R7 R11 burst beat %0d", i - 5), 1'b1, pat(order[i - 5]));
      end
    end
    interleave = 1'b0;

    // R7 deselect continuation
    drive(1'b0, 1'b1, 1'b0, 8'hFF, 6'd0, 72'h0); tick();
    drive(1'b1, 1'b1, 1'b1, 8'hFF, 6'd4, 72'h0); tick();
    drive(1'b1, 1'b1, 1'b1, 8'hFF, 6'd4, 72'h0); tick();
    expect_out("R7 deselect continue", 1'b0, 72'h0);
    drive(1'b0, 1'b1, 1'b0, 8'hFF, 6'd0, 72'h0); tick();
    expect_out("R7 deselect continue second", 1'b0, 72'h0);
    tick(); tick();

    // R5 flow-through timing
    flow_thru = 1'b1;
    drive(1'b0, 1'b0, 1'b1, 8'h00, 6'd12, 72'h0); tick();
    expect_out("R5 R9 flow write cycle", 1'b0, 72'h0);
    drive(1'b0, 1'b1, 1'b1, 8'hFF, 6'd12, DX); tick();
    expect_out("R5 flow read after write", 1'b1, DX);
    drive(1'b0, 1'b0, 1'b1, 8'hF0, 6'd12, 72'h0); tick();
    expect_out("R5 R9 flow partial write cycle", 1'b0, 72'h0);
    drive(1'b0, 1'b1, 1'b1, 8'hFF, 6'd12, DY); tick();
    expect_out("R5 R6 flow merged lanes", 1'b1, {DX[71:36], DY[35:0]});
    drive(1'b0, 1'b1, 1'b0, 8'hFF, 6'd0, 72'h0); tick();
    expect_out("R5 flow deselect", 1'b0, 72'h0);

    summary();
    $finish;
  end
endmodule